// File: doc/BRIEF.md
# Drift service-request latch with poll responder

This block turns a drift warning from an external window comparator into a single outstanding service request toward a host controller. Two warning levels (one for drift toward the high limit, one toward the low limit) are synchronised to the block clock. A rising edge of their OR starts a set pulse that latches the request. While latched, the active-low request output is asserted and a poll response path is armed.

The host talks to the block over an 8-bit open-drain data bus. The bus is modelled as a vector of drive-low enables (`bus_pull_o`) together with the wired bus value read back on `bus_i`. During a poll, with the poll strobe and the high address line both high, the block identifies itself by pulling its identity line low. The host confirms by holding that same line low while it drops the address line. On that falling edge the request clears.

The host can also read both warning levels as status bits on the bus through a separate read strobe. The bus read-back and the status read strobe are assumed to be synchronous to the block clock.

Top module: `srq_poll_unit`

## Requirements
- R1: `drift_hi_i`, `drift_lo_i`, `poll_i` and `addr_hi_i` each pass through two register stages before any use. When a warning input rises after a clock edge, `req_n_o` goes low at the third following rising clock edge and not before.
- R2: Synchronous active-low reset: on the first clock edge with `rst_n` low, `req_n_o` goes to 1 and every bit of `bus_pull_o` goes to 0. `req_n_o` is active low and is 0 exactly while the request is latched.
- R3: A rising edge of the OR of the two synchronised warning levels sets the request when it is clear. A warning level that stays high does not set the request again after it has been cleared.
- R4: The set pulse lasts `SET_CYC` cycles, counting from the cycle of the edge. An acknowledge attempted while the pulse is active does not clear the request.
- R5: `bus_pull_o[ID_BIT]` (bit 2 by default) is 1 exactly when the request is latched and the synchronised poll and address levels are both high.
- R6: While the request is clear, the poll path never drives `bus_pull_o[ID_BIT]`, whatever `poll_i` and `addr_hi_i` do.
- R7: A falling edge of the synchronised address level clears the request at that clock edge, provided the set pulse is over and `bus_i[ID_BIT]` reads 0. `req_n_o` returns to 1 after that edge.
- R8: A falling edge of the synchronised address level with `bus_i[ID_BIT]` reading 1 leaves the request latched.
- R9: A new warning edge while the request is latched is ignored. It neither extends the set pulse nor leaves a second request pending once the first is acknowledged.
- R10: While `stat_rd_i` is 1, `bus_pull_o[HI_BIT]` (bit 0) is the inverse of the synchronised high-drift level and `bus_pull_o[LO_BIT]` (bit 1) is the inverse of the synchronised low-drift level, so each bus line reads 1 when its warning is active. While `stat_rd_i` is 0, both bits are 0.
- R11: `bus_pull_o` bits 3 to 7 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| drift_hi_i | input | 1 | Warning: loop near its high limit (asynchronous) |
| drift_lo_i | input | 1 | Warning: loop near its low limit (asynchronous) |
| poll_i | input | 1 | Host poll strobe (asynchronous) |
| addr_hi_i | input | 1 | Host high address line; its fall is the acknowledge (asynchronous) |
| stat_rd_i | input | 1 | Host status read strobe (synchronous) |
| bus_i | input | DATA_W | Wired data bus value read back |
| bus_pull_o | output | DATA_W | Per-line drive-low enables onto the data bus |
| req_n_o | output | 1 | Service request, active low |

## Verification
The bench builds the block with `SET_CYC` = 20 and the default two synchroniser stages, leaving the other parameters at their defaults. The short set pulse lets one run hit both cases: an acknowledge that lands inside the pulse, and one that lands after it. The same run also covers a refused acknowledge, a second warning edge during a pending request, a warning level that stays high after a clear, and a reset taken mid-request. A behavioural model fed by the same stimulus is compared against `req_n_o` and every `bus_pull_o` bit on every clock.

// File: rtl/srq_pkg.sv
// Package: shared types for the service-request block.
// Assumes: nothing; holds only the grouping of the asynchronous host/sensor levels.
package srq_pkg;

    // Asynchronous levels that share one synchroniser bank.
    typedef struct packed {
        logic hi;     // drift toward high limit
        logic lo;     // drift toward low limit
        logic poll;   // host poll strobe
        logic addr;   // host high address line
    } srq_async_t;

    localparam int unsigned ASYNC_W = $bits(srq_async_t);

endpackage

// File: rtl/srq_sync.sv
// Module: srq_sync
// Multi-stage synchroniser bank for W independent single-bit levels.
// Assumes: each bit is a level, not a pulse shorter than a clock period;
// STAGES >= 1; output is the last stage.
module srq_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= d_i;
            end
        end else begin : g_chain
            // Shift each level one stage deeper per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/srq_set_pulse.sv
// Module: srq_set_pulse
// Detects a rising edge of the OR of the two drift levels and stretches it
// into a set pulse of PULSE_CYC cycles. A new pulse starts only when armed.
// Assumes: levels are already synchronised; PULSE_CYC >= 1.
module srq_set_pulse #(
    parameter int unsigned PULSE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_i,    // OR of synchronised drift levels
    input  logic armed_i,   // request currently clear
    output logic start_o,   // first cycle of a pulse
    output logic hold_o     // pulse active (start cycle included)
);

    localparam int unsigned CW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

    logic          warn_prev_q;
    logic [CW-1:0] cnt_q;

    // Remember last warning level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) warn_prev_q <= 1'b0;
        else        warn_prev_q <= warn_i;
    end

    assign start_o = warn_i && !warn_prev_q && armed_i && (cnt_q == '0);
    assign hold_o  = start_o || (cnt_q != '0);

    // Count down the remaining cycles of the set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_o)        cnt_q <= LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // R4: a started pulse loads its full remaining length.
    p_pulse_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (cnt_q == LOAD));

    // R9: no new pulse can start while one is running.
    p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> !start_o);

endmodule

// File: rtl/srq_req_latch.sv
// Module: srq_req_latch
// The request latch: set while the set pulse is active, cleared by a falling
// edge of the address level while the identity bus line reads low.
// Assumes: address level synchronised; bus read-back synchronous to clk.
module srq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_hold_i,  // set pulse active (dominates clear)
    input  logic addr_i,      // synchronised address level
    input  logic line_low_i,  // identity line reads low on the bus
    output logic req_o
);

    logic addr_prev_q;
    logic ack_fall;

    // Remember last address level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_prev_q <= 1'b0;
        else        addr_prev_q <= addr_i;
    end

    assign ack_fall = addr_prev_q && !addr_i;

    // Set-dominant request latch with handshake clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                req_o <= 1'b0;
        else if (set_hold_i)                       req_o <= 1'b1;
        else if (req_o && ack_fall && line_low_i)  req_o <= 1'b0;
    end

    // R3: an active set pulse leaves the request latched.
    p_set_on_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_hold_i |=> req_o);

    // R7: the request only drops after a qualified acknowledge.
    p_clear_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !set_hold_i && ack_fall && line_low_i) |=> !req_o);

    // R8: an acknowledge with the line high keeps the request.
    p_keep_on_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_fall && !line_low_i) |=> req_o);

endmodule

// File: rtl/srq_bus_drv.sv
// Module: srq_bus_drv
// Builds per-line drive-low enables: identity line during a poll, two status
// lines during a status read, nothing on any other line.
// Assumes: ID_BIT, HI_BIT and LO_BIT are distinct and below DATA_W.
module srq_bus_drv #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ID_BIT = 2,
    parameter int unsigned HI_BIT = 0,
    parameter int unsigned LO_BIT = 1
) (
    input  logic              req_i,
    input  logic              poll_i,
    input  logic              addr_i,
    input  logic              stat_rd_i,
    input  logic              hi_i,
    input  logic              lo_i,
    output logic [DATA_W-1:0] pull_o
);

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_line
            if (b == ID_BIT) begin : g_id
                assign pull_o[b] = req_i && poll_i && addr_i;
            end else if (b == HI_BIT) begin : g_hi
                assign pull_o[b] = stat_rd_i && !hi_i;
            end else if (b == LO_BIT) begin : g_lo
                assign pull_o[b] = stat_rd_i && !lo_i;
            end else begin : g_idle
                assign pull_o[b] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/srq_poll_unit.sv
// Module: srq_poll_unit (top)
// Drift service-request latch with poll responder and status read.
// Assumes: drift, poll and address inputs asynchronous; stat_rd_i and bus_i
// synchronous to clk; bus_i is the wired-AND of all drivers on the bus.
module srq_poll_unit #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ID_BIT      = 2,
    parameter int unsigned HI_BIT      = 0,
    parameter int unsigned LO_BIT      = 1,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SET_CYC     = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drift_hi_i,
    input  logic              drift_lo_i,
    input  logic              poll_i,
    input  logic              addr_hi_i,
    input  logic              stat_rd_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] bus_pull_o,
    output logic              req_n_o
);
    import srq_pkg::*;

    srq_async_t raw, syn;
    logic       start, hold, req;

    assign raw = '{hi: drift_hi_i, lo: drift_lo_i, poll: poll_i, addr: addr_hi_i};

    srq_sync #(.W(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    srq_set_pulse #(.PULSE_CYC(SET_CYC)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .warn_i  (syn.hi || syn.lo),
        .armed_i (!req),
        .start_o (start),
        .hold_o  (hold)
    );

    srq_req_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_hold_i (hold),
        .addr_i     (syn.addr),
        .line_low_i (!bus_i[ID_BIT]),
        .req_o      (req)
    );

    srq_bus_drv #(.DATA_W(DATA_W), .ID_BIT(ID_BIT), .HI_BIT(HI_BIT), .LO_BIT(LO_BIT)) u_bus (
        .req_i     (req),
        .poll_i    (syn.poll),
        .addr_i    (syn.addr),
        .stat_rd_i (stat_rd_i),
        .hi_i      (syn.hi),
        .lo_i      (syn.lo),
        .pull_o    (bus_pull_o)
    );

    assign req_n_o = !req;

    // R6: with no request pending the identity line is never pulled.
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_n_o |-> !bus_pull_o[ID_BIT]);

    // R2: the cycle after reset the request output is released.
    p_reset_release_r2: assert property (@(posedge clk)
        !rst_n |=> req_n_o);

endmodule

// File: tb/srq_poll_unit_tb_top.sv
// Bench: directed stimulus plus a behavioural reference model compared every clock.
module srq_poll_unit_tb_top;

    localparam int DW = 8;
    localparam int ID = 2;
    localparam int SETC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 0, lo = 0, poll = 0, addr = 0, srd = 0;
    logic [DW-1:0] host_pull = '0;
    logic [DW-1:0] pull;
    logic [DW-1:0] bus;
    logic req_n;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign bus = ~(pull | host_pull);

    srq_poll_unit #(.SET_CYC(SETC)) dut_i (
        .clk(clk), .rst_n(rst_n), .drift_hi_i(hi), .drift_lo_i(lo),
        .poll_i(poll), .addr_hi_i(addr), .stat_rd_i(srd),
        .bus_i(bus), .bus_pull_o(pull), .req_n_o(req_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_hi[$], m_lo[$], m_poll[$], m_addr[$];
    bit m_req, m_warn_prev, m_addr_prev;
    int m_cnt;

    function automatic bit last(ref bit q[$]);
        return q[q.size()-1];
    endfunction

    initial begin
        repeat (2) begin m_hi.push_back(0); m_lo.push_back(0); m_poll.push_back(0); m_addr.push_back(0); end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = '{0, 0}; m_lo = '{0, 0}; m_poll = '{0, 0}; m_addr = '{0, 0};
            m_req = 0; m_warn_prev = 0; m_addr_prev = 0; m_cnt = 0;
        end else begin
            bit warn, start, holdp, fall;
            warn  = last(m_hi) | last(m_lo);
            start = warn && !m_warn_prev && !m_req && m_cnt == 0;
            holdp = start || m_cnt > 0;
            fall  = m_addr_prev && !last(m_addr);
            if (holdp) m_req = 1;
            else if (m_req && fall && !bus[ID]) m_req = 0;
            m_cnt = start ? SETC - 1 : (m_cnt > 0 ? m_cnt - 1 : 0);
            m_warn_prev = warn;
            m_addr_prev = last(m_addr);
            void'(m_hi.pop_back());   m_hi.push_front(hi);
            void'(m_lo.pop_back());   m_lo.push_front(lo);
            void'(m_poll.pop_back()); m_poll.push_front(poll);
            void'(m_addr.pop_back()); m_addr.push_front(addr);
        end
    end

    // Compare every bus line and the request output away from the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            bit [DW-1:0] e;
            e = '0;
            e[ID] = m_req && last(m_poll) && last(m_addr);
            e[0]  = srd && !last(m_hi);
            e[1]  = srd && !last(m_lo);
            check(req_n == !m_req, "R2 model req_n", req_n, !m_req);
            check(pull[ID] == e[ID], "R5 model id line", pull[ID], e[ID]);
            check(pull[1:0] == e[1:0], "R10 model status lines", pull[1:0], e[1:0]);
            check(pull[DW-1:3] == '0, "R11 model spare lines", pull[DW-1:3], 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drv;  // align driving to the falling edge
        @(negedge clk);
    endtask

    // Host acknowledge: raise address, then drop it with identity line held or not.
    task automatic ack(input bit hold_line);
        drv; addr = 1; cyc(4);
        drv; host_pull[ID] = hold_line; addr = 0; cyc(4);
        drv; host_pull[ID] = 0;
    endtask

    initial begin
        cyc(3);
        check(req_n == 1, "R2 reset req_n", req_n, 1);
        check(pull == '0, "R2 reset pull", pull, 0);
        drv; rst_n = 1;
        cyc(2);

        // R1: latency of the two stages plus edge register.
        drv; hi = 1;
        cyc(2);
        check(req_n == 1, "R1 not yet latched", req_n, 1);
        cyc(1);
        check(req_n == 0, "R1 latched at third edge", req_n, 0);

        // R4: acknowledge inside the set pulse is refused.
        drv; poll = 1;
        ack(1);
        check(req_n == 0, "R4 ack during set pulse ignored", req_n, 0);

        cyc(SETC);
        // R5: poll with address high pulls identity line.
        drv; addr = 1; cyc(3);
        check(pull[ID] == 1, "R5 id line during poll", pull[ID], 1);
        check(bus[ID] == 0, "R5 bus identity line low", bus[ID], 0);
        drv; addr = 0; cyc(3);

        // R8: acknowledge without identity line held keeps request.
        ack(0);
        check(req_n == 0, "R8 nack keeps request", req_n, 0);

        // R9: a new edge while latched is ignored.
        drv; hi = 0; cyc(4);
        drv; lo = 1; cyc(4);
        ack(1);
        check(req_n == 1, "R7 ack clears request", req_n, 1);
        check(req_n == 1, "R9 no second request pending", req_n, 1);

        // R6: poll after clear never drives identity line.
        drv; addr = 1; cyc(4);
        check(pull[ID] == 0, "R6 quiet when clear", pull[ID], 0);
        // R3: a level held high does not re-set the request.
        check(req_n == 1, "R3 held level no re-set", req_n, 1);
        drv; addr = 0; poll = 0;

        // R10: status read of the warning levels.
        drv; srd = 1; cyc(1);
        check(pull[0] == 1, "R10 hi inactive pulled", pull[0], 1);
        check(pull[1] == 0, "R10 lo active released", pull[1], 0);
        check(bus[1:0] == 2'b10, "R10 bus status", bus[1:0], 2);
        drv; srd = 0; cyc(1);
        check(pull[1:0] == 0, "R10 no read no drive", pull[1:0], 0);
        check(pull[DW-1:3] == 0, "R11 spare lines idle", pull[DW-1:3], 0);

        // R3: fresh edge after both levels drop sets again.
        drv; lo = 0; cyc(4);
        drv; hi = 1; cyc(3);
        check(req_n == 0, "R3 new edge sets", req_n, 0);

        // R2: reset mid-request.
        drv; rst_n = 0; poll = 1; addr = 1; cyc(1);
        check(req_n == 1, "R2 reset releases request", req_n, 1);
        check(pull == 0, "R2 reset releases bus", pull, 0);
        drv; rst_n = 1; poll = 0; addr = 0; hi = 0; cyc(5);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule